// File: doc/BRIEF.md
# Shot Scoring Game Controller

This block keeps score for a one-player arcade basketball game. Two sensor flags describe each shot. One flag reports a backboard contact and the other reports that the ball passed through the rim. A one-cycle strobe marks the cycle in which the shot is complete. On that strobe the controller classifies the shot and updates a running score. The score cannot drop below zero and cannot pass the winning total.

When the score reaches the winning total (three points by default), the controller enters a win state and turns on a win light. The win state ignores all further shots. Only a synchronous reset or a new-game request clears it. The score is also driven out as a small binary value, so the surrounding logic can show it or check it.

All state is held in D flip-flops clocked on the rising edge. The score register updates on the clock edge that follows the strobe cycle.

Top module: `shot_score_ctrl`

## Requirements
- R1: While `rst_i` is high at a rising edge, the next state is score 0 with `win_o` low.
- R2: A strobed shot with both `board_i` and `rim_i` high adds one point, visible after the next rising edge.
- R3: A strobed shot with `rim_i` high and `board_i` low adds two points. If the sum would pass the winning total, the score stops at the winning total.
- R4: A strobed shot with `board_i` high and `rim_i` low subtracts one point. At score 0 the score stays 0.
- R5: A strobed shot with both flags low leaves the score unchanged.
- R6: When `shot_done_i` is low, the sensor flags have no effect on the score.
- R7: `win_o` is high exactly when `score_o` equals the winning total (3 by default). In that state, strobed shots of every kind leave both outputs unchanged.
- R8: `new_game_i` high at a rising edge returns the score to 0 with `win_o` low. It has the same effect during play and in the win state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| new_game_i | input | 1 | Synchronous restart request, active high |
| shot_done_i | input | 1 | One-cycle strobe that marks the end of a shot |
| board_i | input | 1 | Backboard contact flag for the current shot |
| rim_i | input | 1 | Rim pass flag for the current shot |
| score_o | output | SCORE_W | Current score as an unsigned binary value |
| win_o | output | 1 | Win light |

## Verification
On every cycle the assertions check the following: reset and new-game clear the state, the score holds while no shot is strobed, the win light agrees with the score, the win state holds, a bank shot adds one, the score floors at zero, and a no-shot has no effect. Only the bench scenarios can show that each point value is applied across a whole game. Those scenarios cover a two-point shot taken from two, which stops at three. They also cover flags toggling off-strobe and a mid-game restart, each followed by later play, which shows the score history is consistent from one step to the next.

// File: rtl/shot_score_pkg.sv
package shot_score_pkg;

   typedef enum logic [1:0] {
      SHOT_NONE  = 2'd0,
      SHOT_BANK  = 2'd1,
      SHOT_SWISH = 2'd2,
      SHOT_MISS  = 2'd3
   } shot_kind_e;

   function automatic int score_width(input int win_total);
      return $clog2(win_total + 1);
   endfunction

endpackage

// File: rtl/shot_classify.sv
module shot_classify
   import shot_score_pkg::*;
(
   input  logic       valid_i,
   input  logic       board_i,
   input  logic       rim_i,
   output shot_kind_e kind_o
);

   always_comb begin
      kind_o = SHOT_NONE;
      if (valid_i) begin
         unique case ({board_i, rim_i})
            2'b11:   kind_o = SHOT_BANK;
            2'b01:   kind_o = SHOT_SWISH;
            2'b10:   kind_o = SHOT_MISS;
            default: kind_o = SHOT_NONE;
         endcase
      end
   end

endmodule

// File: rtl/score_step.sv
module score_step
   import shot_score_pkg::*;
#(
   parameter int WIN_SCORE = 3,
   parameter int SCORE_W   = score_width(WIN_SCORE)
) (
   input  logic [SCORE_W-1:0] cur_i,
   input  shot_kind_e         kind_i,
   output logic [SCORE_W-1:0] nxt_o
);

   localparam logic [SCORE_W:0]   WIN_WIDE = (SCORE_W+1)'(WIN_SCORE);
   localparam logic [SCORE_W-1:0] WIN_V    = SCORE_W'(WIN_SCORE);

   logic [SCORE_W:0] cur_wide;
   logic [SCORE_W:0] sum;

   assign cur_wide = {1'b0, cur_i};

   always_comb begin
      sum = cur_wide;
      unique case (kind_i)
         SHOT_BANK:  sum = cur_wide + (SCORE_W+1)'(1);
         SHOT_SWISH: sum = cur_wide + (SCORE_W+1)'(2);
         SHOT_MISS:  sum = (cur_wide == '0) ? '0 : cur_wide - (SCORE_W+1)'(1);
         default:    sum = cur_wide;
      endcase
   end

   always_comb begin
      if (cur_wide >= WIN_WIDE)
         nxt_o = cur_i;
      else if (sum >= WIN_WIDE)
         nxt_o = WIN_V;
      else
         nxt_o = sum[SCORE_W-1:0];
   end

endmodule

// File: rtl/shot_score_ctrl.sv
module shot_score_ctrl
   import shot_score_pkg::*;
#(
   parameter int WIN_SCORE = 3,
   parameter bit WIN_FLOP  = 1'b1,
   parameter int SCORE_W   = score_width(WIN_SCORE)
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               new_game_i,
   input  logic               shot_done_i,
   input  logic               board_i,
   input  logic               rim_i,
   output logic [SCORE_W-1:0] score_o,
   output logic               win_o
);

   localparam logic [SCORE_W-1:0] WIN_V = SCORE_W'(WIN_SCORE);

   if (WIN_SCORE < 2) begin : g_bad_win
      $error("shot_score_ctrl: WIN_SCORE must be at least 2");
   end
   if (SCORE_W != score_width(WIN_SCORE)) begin : g_bad_width
      $error("shot_score_ctrl: SCORE_W does not match WIN_SCORE");
   end

   shot_kind_e         kind;
   logic [SCORE_W-1:0] score_q;
   logic [SCORE_W-1:0] score_d;
   logic               clear;

   assign clear = rst_i | new_game_i;

   shot_classify i_classify (
      .valid_i (shot_done_i),
      .board_i (board_i),
      .rim_i   (rim_i),
      .kind_o  (kind)
   );

   score_step #(
      .WIN_SCORE (WIN_SCORE),
      .SCORE_W   (SCORE_W)
   ) i_step (
      .cur_i  (score_q),
      .kind_i (kind),
      .nxt_o  (score_d)
   );

   always_ff @(posedge clk_i) begin
      if (clear)
         score_q <= '0;
      else
         score_q <= score_d;
   end

   if (WIN_FLOP) begin : g_win_reg
      logic win_q;
      always_ff @(posedge clk_i) begin
         if (clear)
            win_q <= 1'b0;
         else
            win_q <= (score_d == WIN_V);
      end
      assign win_o = win_q;
   end else begin : g_win_dec
      assign win_o = (score_q == WIN_V);
   end

   assign score_o = score_q;

endmodule

// File: rtl/shot_score_ctrl_chk.sv
module shot_score_ctrl_chk #(
   parameter int WIN_SCORE = 3,
   parameter int SCORE_W   = 2
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic               new_game_i,
   input logic               shot_done_i,
   input logic               board_i,
   input logic               rim_i,
   input logic [SCORE_W-1:0] score_o,
   input logic               win_o
);

   localparam logic [SCORE_W-1:0] WIN_V = SCORE_W'(WIN_SCORE);

   logic live;
   assign live = !rst_i && !new_game_i;

   // R1
   a_r1_reset_clears: assert property (@(posedge clk_i)
      rst_i |=> (score_o == '0) && !win_o);

   // R8
   a_r8_new_game_clears: assert property (@(posedge clk_i) disable iff (rst_i)
      new_game_i |=> (score_o == '0) && !win_o);

   // R6
   a_r6_idle_holds: assert property (@(posedge clk_i) disable iff (rst_i)
      live && !shot_done_i |=> $stable(score_o));

   // R7
   a_r7_light_matches: assert property (@(posedge clk_i) disable iff (rst_i)
      win_o == (score_o == WIN_V));

   // R7
   a_r7_win_absorbs: assert property (@(posedge clk_i) disable iff (rst_i)
      live && win_o |=> win_o && $stable(score_o));

   // R2
   a_r2_bank_adds_one: assert property (@(posedge clk_i) disable iff (rst_i)
      live && !win_o && shot_done_i && board_i && rim_i
      |=> score_o == $past(score_o) + SCORE_W'(1));

   // R4
   a_r4_floor_at_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      live && shot_done_i && board_i && !rim_i && (score_o == '0)
      |=> score_o == '0);

   // R5
   a_r5_no_shot_holds: assert property (@(posedge clk_i) disable iff (rst_i)
      live && shot_done_i && !board_i && !rim_i |=> $stable(score_o));

endmodule

bind shot_score_ctrl shot_score_ctrl_chk #(
   .WIN_SCORE (WIN_SCORE),
   .SCORE_W   (SCORE_W)
) i_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .new_game_i  (new_game_i),
   .shot_done_i (shot_done_i),
   .board_i     (board_i),
   .rim_i       (rim_i),
   .score_o     (score_o),
   .win_o       (win_o)
);

// File: tb/test_shot_score_ctrl.sv
`timescale 1ns/1ps
module test_shot_score_ctrl;

   localparam int WIN = 3;
   localparam int W   = 2;

   typedef struct {
      int    score;
      bit    win;
      string req;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         ng = 1'b0;
   logic         done = 1'b0;
   logic         board = 1'b0;
   logic         rim = 1'b0;
   logic [W-1:0] score;
   logic         win;

   int   checks = 0;
   int   errors = 0;
   int   model = 0;
   bit   finished = 1'b0;
   exp_t q[$];

   always #5 clk = ~clk;

   shot_score_ctrl i_shot_score_ctrl (
      .clk_i       (clk),
      .rst_i       (rst),
      .new_game_i  (ng),
      .shot_done_i (done),
      .board_i     (board),
      .rim_i       (rim),
      .score_o     (score),
      .win_o       (win)
   );

   // monitor: compares one expected item after each rising edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (int'(score) != e.score || win != e.win) begin
            errors++;
            $display("FAIL %s: score=%0d win=%0b expected score=%0d win=%0b",
                     e.req, score, win, e.score, e.win);
         end
      end
   end

   // driver: applies one cycle of stimulus and queues the expected outputs
   task automatic step(input bit r, input bit n, input bit d,
                       input bit b, input bit m, input string req);
      exp_t e;
      @(negedge clk);
      rst = r; ng = n; done = d; board = b; rim = m;
      if (r || n)
         model = 0;
      else if (d && model < WIN) begin
         if (b && m)       model = model + 1;
         else if (!b && m) model = model + 2;
         else if (b && !m) model = (model == 0) ? 0 : model - 1;
         if (model > WIN)  model = WIN;
      end
      e.score = model;
      e.win   = (model == WIN);
      e.req   = req;
      q.push_back(e);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      step(1, 0, 0, 0, 0, "R1");            // reset state
      step(0, 0, 0, 1, 1, "R6");            // flags without strobe
      step(0, 0, 0, 0, 1, "R6");
      step(0, 0, 1, 1, 0, "R4");            // loss at zero floors
      step(0, 0, 1, 0, 0, "R5");            // no-shot
      step(0, 0, 1, 1, 1, "R2");            // 0 -> 1
      step(0, 0, 0, 1, 0, "R6");
      step(0, 0, 1, 1, 0, "R4");            // 1 -> 0
      step(0, 0, 1, 0, 1, "R3");            // 0 -> 2
      step(0, 0, 1, 0, 0, "R5");
      step(0, 0, 1, 1, 0, "R4");            // 2 -> 1
      step(0, 0, 1, 1, 1, "R2");            // 1 -> 2
      step(0, 0, 1, 0, 1, "R3");            // 2 -> 3 saturates, win
      step(0, 0, 1, 1, 0, "R7");            // ignored in win
      step(0, 0, 1, 0, 1, "R7");
      step(0, 0, 1, 1, 1, "R7");
      step(0, 1, 0, 0, 0, "R8");            // restart from win
      step(0, 0, 1, 1, 1, "R2");            // 0 -> 1
      step(0, 0, 1, 1, 1, "R2");            // 1 -> 2
      step(0, 0, 1, 1, 1, "R7");            // 2 -> 3 via bank shots
      step(0, 1, 1, 0, 1, "R8");            // new game beats a strobe
      step(0, 0, 1, 0, 1, "R3");            // 0 -> 2
      step(1, 0, 1, 1, 1, "R1");            // reset mid-game
      step(0, 0, 1, 0, 1, "R3");            // 0 -> 2
      step(0, 0, 1, 0, 1, "R3");            // 2 -> 3 saturates
      step(0, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 0, 0, "R7");
      @(negedge clk);
      @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule